// File: doc/BRIEF.md
# Power-Up Partner Presence Detector

This block runs once after every reset, during the first initialization phase of a node on a two-wire sensor bus. Its job is to find out whether a second node sits in series on the same line. When its enable bit is set, it asks the analog front end to sink a detection current, and it watches a digitized current-sense comparator. While it watches, it counts microsecond ticks from a shared timebase.

The comparator level passes through a two-flop synchronizer. It is then sampled at twelve fixed points, one every 500 ticks, across a 6000-tick window. A partner is declared only when four consecutive samples read high, and any low sample restarts the run. At the close of the window the block drops the sink request, sets a done flag and latches the partner result. Both hold until the next reset. A slot scheduler reads the latched result: with no partner, the node uses the first transmit slot.

The controller is a four-state machine:
- `ST_IDLE`: the reset state. It reads the enable bit once.
- `ST_WINDOW`: the sink request is active and samples are taken.
- `ST_LATCH`: a one-cycle state in which the last sample settles into the run qualifier.
- `ST_DONE`: the terminal state.

The transitions are:
- `IDLE->WINDOW` when enabled.
- `IDLE->DONE` when disabled (the bypass).
- `WINDOW->LATCH` on the twelfth sample strobe.
- `LATCH->DONE` unconditionally.

Top module: `pwrup_partner_detect`

## Requirements
- R1: While reset is asserted, `sink_req`, `det_done` and `partner_present` are all 0.
- R2: If `cfg_auto_en` is 0 at the first clock edge after reset release, `sink_req` never rises. `det_done` is 1 from that edge onward and `partner_present` stays 0.
- R3: If `cfg_auto_en` is 1 at that edge, `sink_req` rises at that edge and stays high for exactly 6000 `tick_us` pulses (12 samples x 500 ticks).
- R4: `sense_in` (1 = valid current seen) goes through a two-stage synchronizer. It is sampled only on the 500th, 1000th, ..., 6000th tick of the window, and its level between sample points has no effect.
- R5: Four consecutive high samples anywhere among the 12 set the result to 1. This includes a run that ends on the twelfth sample.
- R6: A low sample clears the consecutive count to zero. Runs of three separated by lows give a result of 0, and so does a window with no qualifying run.
- R7: `det_done` rises, and `partner_present` takes its final value, one clock cycle after `sink_req` falls.
- R8: Once `det_done` is 1, `det_done` and `partner_present` hold until reset, whatever `sense_in` and `cfg_auto_en` do.
- R9: Changes on `cfg_auto_en` after the first edge following reset have no effect on the window or the result.
- R10: The window is measured in `tick_us` pulses, not clock cycles. With ticks on every other cycle, `sink_req` lasts twice as many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, marks power-up |
| cfg_auto_en | input | 1 | Enable for partner detection, read once after reset |
| sense_in | input | 1 | Asynchronous current-sense comparator output, 1 = current seen |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| sink_req | output | 1 | Request to the analog front end to sink the detection current |
| det_done | output | 1 | Detection finished, result valid |
| partner_present | output | 1 | Latched result: 1 = a series partner was found |

## Verification
A fault in the tick or sample counters shows up as a wrong `sink_req` length, which can be measured exactly at the falling edge, about 6000 ticks after reset. A fault in the run counter, such as failing to clear on a low sample or an off-by-one threshold, stays hidden until the window closes. It then appears as a wrong `partner_present` one cycle after `sink_req` falls. The sense patterns are therefore chosen to sit right on the run-length boundary: runs at the start, at the end, and of three. A wrong state after the window appears as `det_done` or `partner_present` moving while sense and the enable bit are toggled for more than a thousand cycles.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_LATCH  = 2'd2,
        ST_DONE   = 2'd3
    } pdet_state_e;

endpackage

// File: rtl/pdet_sync.sv
module pdet_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pdet_schedule.sv
module pdet_schedule #(
    parameter int TICKS_PER_SAMPLE = 500,
    parameter int NUM_SAMPLES      = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick,
    output logic sample_stb,
    output logic last_stb
);

    localparam int TW = (TICKS_PER_SAMPLE > 1) ? $clog2(TICKS_PER_SAMPLE) : 1;
    localparam int SW = (NUM_SAMPLES > 1) ? $clog2(NUM_SAMPLES) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_SAMPLE - 1);
    localparam logic [SW-1:0] SAMP_LAST = SW'(NUM_SAMPLES - 1);

    logic [TW-1:0] tick_cnt_q;
    logic [SW-1:0] samp_cnt_q;
    logic          interval_end;

    assign interval_end = run_en && tick && (tick_cnt_q == TICK_LAST);
    assign sample_stb   = interval_end;
    assign last_stb     = interval_end && (samp_cnt_q == SAMP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
            samp_cnt_q <= '0;
        end else if (!run_en) begin
            tick_cnt_q <= '0;
            samp_cnt_q <= '0;
        end else if (tick) begin
            if (interval_end) begin
                tick_cnt_q <= '0;
                if (samp_cnt_q != SAMP_LAST) samp_cnt_q <= samp_cnt_q + 1'b1;
            end else begin
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdet_runqual.sv
module pdet_runqual #(
    parameter int RUN_NEEDED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_stb,
    input  logic sample_val,
    output logic qualified
);

    localparam int RW = $clog2(RUN_NEEDED + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(RUN_NEEDED);
    localparam logic [RW-1:0] RUN_PRE  = RW'(RUN_NEEDED - 1);

    logic [RW-1:0] run_q;
    logic          qual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            qual_q <= 1'b0;
        end else if (clear) begin
            run_q  <= '0;
            qual_q <= 1'b0;
        end else if (sample_stb) begin
            if (sample_val) begin
                if (run_q == RUN_PRE) qual_q <= 1'b1;
                if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    assign qualified = qual_q;

endmodule

// File: rtl/pwrup_partner_detect.sv
module pwrup_partner_detect
    import pdet_pkg::*;
#(
    parameter int TICKS_PER_SAMPLE = 500,
    parameter int NUM_SAMPLES      = 12,
    parameter int RUN_NEEDED       = 4,
    parameter int SYNC_STAGES      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_auto_en,
    input  logic sense_in,
    input  logic tick_us,
    output logic sink_req,
    output logic det_done,
    output logic partner_present
);

    pdet_state_e state_q, state_d;
    logic sense_s;
    logic in_window;
    logic sample_stb;
    logic last_stb;
    logic qualified;
    logic partner_q;

    pdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sense_in),
        .q_sync  (sense_s)
    );

    assign in_window = (state_q == ST_WINDOW);

    pdet_schedule #(
        .TICKS_PER_SAMPLE (TICKS_PER_SAMPLE),
        .NUM_SAMPLES      (NUM_SAMPLES)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (in_window),
        .tick       (tick_us),
        .sample_stb (sample_stb),
        .last_stb   (last_stb)
    );

    pdet_runqual #(.RUN_NEEDED(RUN_NEEDED)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state_q == ST_IDLE),
        .sample_stb (sample_stb),
        .sample_val (sense_s),
        .qualified  (qualified)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = cfg_auto_en ? ST_WINDOW : ST_DONE;
            ST_WINDOW: if (last_stb) state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Result latch, written once when leaving ST_LATCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  partner_q <= 1'b0;
        else if (state_q == ST_LATCH) partner_q <= qualified;
    end

    // Outputs
    always_comb begin
        sink_req = 1'b0;
        det_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WINDOW: sink_req = 1'b1;
            ST_LATCH:  ;
            ST_DONE:   det_done = 1'b1;
            default:   ;
        endcase
    end

    assign partner_present = partner_q;

endmodule

// File: rtl/pwrup_partner_detect_chk.sv
module pwrup_partner_detect_chk #(
    parameter int TICKS_PER_SAMPLE = 500,
    parameter int NUM_SAMPLES      = 12
) (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic sink_req,
    input logic det_done,
    input logic partner_present
);

    localparam int WIN_TICKS = TICKS_PER_SAMPLE * NUM_SAMPLES;
    localparam int CW = $clog2(WIN_TICKS + 2);

    logic [CW-1:0] win_ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  win_ticks_q <= '0;
        else if (sink_req && tick_us) win_ticks_q <= win_ticks_q + 1'b1;
    end

    // R3
    sink_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sink_req) |-> (win_ticks_q == CW'(WIN_TICKS)));

    // R3
    sink_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ticks_q <= CW'(WIN_TICKS));

    // R7
    done_after_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sink_req) |=> $rose(det_done));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> (det_done && $stable(partner_present)));

    // R5
    partner_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        partner_present |-> det_done);

    // R2
    no_sink_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |-> !sink_req);

endmodule

bind pwrup_partner_detect pwrup_partner_detect_chk #(
    .TICKS_PER_SAMPLE (TICKS_PER_SAMPLE),
    .NUM_SAMPLES      (NUM_SAMPLES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_us         (tick_us),
    .sink_req        (sink_req),
    .det_done        (det_done),
    .partner_present (partner_present)
);

// File: tb/pwrup_partner_detect_tb.sv
module pwrup_partner_detect_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_en = 1'b0;
    logic sense_in = 1'b0;
    logic tick_us = 1'b0;
    logic sink_req, det_done, partner_present;

    int tick_div = 1;
    int cyc = 0;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick_us <= (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);

    pwrup_partner_detect u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_auto_en     (cfg_auto_en),
        .sense_in        (sense_in),
        .tick_us         (tick_us),
        .sink_req        (sink_req),
        .det_done        (det_done),
        .partner_present (partner_present)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit has_run(input logic [11:0] pat);
        int run = 0;
        bit hit = 0;
        for (int j = 0; j < 12; j++) begin
            if (pat[j]) begin
                run++;
                if (run >= 4) hit = 1;
            end else begin
                run = 0;
            end
        end
        return hit;
    endfunction

    task automatic apply_reset(input bit cfg);
        rst_n = 1'b0;
        cfg_auto_en = cfg;
        sense_in = 1'b0;
        repeat (5) @(negedge clk);
        // R1
        check(sink_req == 0, "R1", "sink_req in reset", sink_req, 0);
        check(det_done == 0, "R1", "det_done in reset", det_done, 0);
        check(partner_present == 0, "R1", "partner in reset", partner_present, 0);
        rst_n = 1'b1;
    endtask

    // R2: bypass when disabled
    task automatic test_bypass();
        int hi = 0;
        tick_div = 1;
        apply_reset(1'b0);
        sense_in = 1'b1;
        @(negedge clk);
        check(det_done == 1, "R2", "done right after reset", det_done, 1);
        for (int n = 0; n < 7000; n++) begin
            if (n == 3000) cfg_auto_en = 1'b1;
            @(negedge clk);
            if (sink_req) hi++;
        end
        check(hi == 0, "R2", "sink cycles when disabled", hi, 0);
        check(partner_present == 0, "R2", "partner when disabled", partner_present, 0);
        check(det_done == 1, "R2", "done held", det_done, 1);
    endtask

    task automatic test_window(input string req, input logic [11:0] pat,
                               input int div, input bit drop_cfg);
        int n = 0;
        int hi = 0;
        int post_hi = 0;
        bit exp_p = has_run(pat);
        int span = 500 * div;
        bit p_final;
        tick_div = div;
        apply_reset(1'b1);
        @(negedge clk);
        check(sink_req == 1, "R3", "sink rises after reset", sink_req, 1);
        while (sink_req && n < 13000 * div) begin
            hi++;
            n++;
            if (n >= span / 2) sense_in = pat[((n - span / 2) / span) % 12];
            if (drop_cfg && n == 1000) cfg_auto_en = 1'b0;   // R9
            @(negedge clk);
        end
        if (div == 1)
            check(hi == 6000, "R3", "sink length in cycles", hi, 6000);
        else
            check(hi >= 6000 * div - div && hi <= 6000 * div, "R10",
                  "sink length with sparse ticks", hi, 6000 * div);
        // R7: one-cycle gap between sink release and done
        check(det_done == 0, "R7", "done low at sink fall", det_done, 0);
        @(negedge clk);
        check(det_done == 1, "R7", "done one cycle after sink fall", det_done, 1);
        check(partner_present == exp_p, req, "partner result", partner_present, exp_p);
        p_final = partner_present;
        // R8: result held while inputs move
        for (int k = 0; k < 1200; k++) begin
            sense_in = ~sense_in;
            if (k % 100 == 0) cfg_auto_en = ~cfg_auto_en;
            @(negedge clk);
            if (sink_req) post_hi++;
            if (!det_done || partner_present != p_final) post_hi += 1000;
        end
        check(post_hi == 0, "R8", "result and done held after window", post_hi, 0);
    endtask

    initial begin
        test_bypass();
        test_window("R5", 12'hFFF, 1, 1'b0);
        test_window("R6", 12'h000, 1, 1'b0);
        test_window("R5", 12'h00F, 1, 1'b0);
        test_window("R5", 12'hF00, 1, 1'b0);
        test_window("R6", 12'b0111_0111_0111, 1, 1'b0);
        test_window("R4", 12'hAAA, 1, 1'b0);
        test_window("R6", 12'b1110_1110_1110, 1, 1'b0);
        test_window("R5", 12'h078, 1, 1'b0);
        test_window("R10", 12'h0F0, 2, 1'b0);
        test_window("R9", 12'hFFF, 1, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule